// File: doc/BRIEF.md
# Staged Instruction Retirement Controller

This controller sits at the old end of an out-of-order instruction window and decides when the oldest instruction may leave it. Each instruction is registered on entry with a small record: which node tables it placed work into, whether it carries I/O operations, and whether it has buffered memory writes. When the instruction reaches the head, the controller steps it through a fixed sequence. First it waits until none of its node tables still holds an unexecuted node from it. Then it releases its I/O operations. After that it releases its memory writes. Only then does it retire it.

I/O is held back until the retirement stage. An I/O access therefore never races a memory write of an older instruction. If an I/O access or a write reports an exception, the controller issues a one-cycle flush naming the head's sequence number. That number marks the repair boundary just before the faulting instruction. The whole window is then discarded. Entry to the window is a valid/ready stream: an instruction is taken only in a cycle where `alloc_valid` and `alloc_ready` are both high. Ready drops when the window is full and during a flush cycle. A source that sees ready low holds its request.

Top module: `retire_ctrl`

## Requirements
- R1: An entry is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both high. It receives the sequence number shown on `alloc_seq`. After reset that number is 0, and it then counts up by one per accepted entry, modulo DEPTH. `alloc_ready` is low while DEPTH entries are held or while `flush_valid` is high, and an offered entry is then not taken.
- R2: The head has finished execution when, for every table whose bit is set in its `alloc_tbl` mask, that table is empty or its oldest unexecuted node carries a sequence number other than the head's. Tables outside the mask are ignored. Until execution has finished, `io_go`, `wr_go` and `retire_valid` stay low.
- R3: A head with I/O raises `io_go`, with `io_seq` equal to its sequence number, only after execution has finished. It holds `io_go` and `io_seq` until a cycle with `io_done` high, and `wr_go` stays low meanwhile.
- R4: A head with writes raises `wr_go`, with `wr_seq` equal to its sequence number. This happens only after its I/O has completed without exception, or after execution if it has no I/O. It holds `wr_go` until `wr_done`. `io_go` and `wr_go` are never high together.
- R5: After its last stage, the head produces a one-cycle `retire_valid` pulse with `retire_seq` equal to its sequence number. A head with writes retires only after a `wr_done` without exception, and the pulse follows that cycle directly. A head with neither I/O nor writes retires straight after execution.
- R6: `io_done` with `io_exc`, or `wr_done` with `wr_exc`, while the matching release is high causes a flush in the next cycle. `flush_valid` is high for one cycle and `flush_seq` equals the head's number. The head does not retire, all entries are dropped, and the next accepted entry takes the flushed head's number.
- R7: In the flush cycle, `io_go`, `wr_go`, `retire_valid` and `alloc_ready` are all low.
- R8: After reset all release, retire and flush outputs are low and `alloc_ready` is high. Instructions retire in sequence order, at most one per cycle, and never in two consecutive cycles.
- R9: `io_done`, `io_exc`, `wr_done` and `wr_exc` have no effect while the matching release signal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New instruction offered to the window |
| alloc_ready | output | 1 | Window can take an instruction this cycle |
| alloc_io | input | 1 | Offered instruction carries I/O operations |
| alloc_wr | input | 1 | Offered instruction carries buffered writes |
| alloc_tbl | input | NTAB | Node tables the offered instruction uses |
| alloc_seq | output | IDX_W | Sequence number the offered instruction receives |
| tbl_empty | input | NTAB | Per table: no unexecuted node left |
| tbl_oldest | input | NTAB*IDX_W | Per table: sequence number of the oldest unexecuted node (table t at bits t*IDX_W) |
| io_go | output | 1 | Release of the head's I/O operations |
| io_seq | output | IDX_W | Sequence number whose I/O is released |
| io_done | input | 1 | I/O operations finished |
| io_exc | input | 1 | I/O finished with an exception |
| wr_go | output | 1 | Release of the head's memory writes |
| wr_seq | output | IDX_W | Sequence number whose writes are released |
| wr_done | input | 1 | Writes performed |
| wr_exc | input | 1 | Writes ended with an exception |
| retire_valid | output | 1 | One-cycle retirement pulse |
| retire_seq | output | IDX_W | Sequence number retired |
| flush_valid | output | 1 | One-cycle repair request |
| flush_seq | output | IDX_W | Boundary: first discarded sequence number |

## Verification
The bench aims at a head whose tables still look busy. A controller that ignored the table state would release I/O or retire early. A controller that ignored the usage mask would stall forever on a table the instruction never used. It injects exceptions in the I/O and write stages. A design that retired the faulting instruction, or kept the younger entries, would show a wrong flush number or a stale next sequence number. Stray done and exception pulses outside their stage must not start a flush. A full window must refuse entries, and the sequence numbers must wrap cleanly across the power-of-two boundary.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_EXEC = 3'd1,
    ST_DO_IO     = 3'd2,
    ST_DO_WRITES = 3'd3,
    ST_RETIRE    = 3'd4,
    ST_FLUSH     = 3'd5
  } rstate_e;
endpackage

// File: rtl/retire_window.sv
module retire_window #(
  parameter int DEPTH = 8,
  parameter int NTAB  = 3,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_io,
  input  logic             push_wr,
  input  logic [NTAB-1:0]  push_tbl,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty,
  output logic             more_after_pop,
  output logic             head_io,
  output logic             head_wr,
  output logic [NTAB-1:0]  head_tbl
);
  localparam int CNT_W = IDX_W + 1;

  logic [DEPTH-1:0] io_q;
  logic [DEPTH-1:0] wr_q;
  logic [NTAB-1:0]  tbl_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign more_after_pop = (cnt_q > CNT_W'(1)) || push;
  assign head_io  = io_q[head_q];
  assign head_wr  = wr_q[head_q];
  assign head_tbl = tbl_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + IDX_W'(1);
      if (pop)  head_q <= head_q + IDX_W'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        io_q[e]  <= 1'b0;
        wr_q[e]  <= 1'b0;
        tbl_q[e] <= '0;
      end else if (push && !flush && tail_q == IDX_W'(e)) begin
        io_q[e]  <= push_io;
        wr_q[e]  <= push_wr;
        tbl_q[e] <= push_tbl;
      end
    end
  end
endmodule

// File: rtl/retire_exec_chk.sv
module retire_exec_chk #(
  parameter int NTAB  = 3,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0]      head_idx,
  input  logic [NTAB-1:0]       head_tbl,
  input  logic [NTAB-1:0]       tbl_empty,
  input  logic [NTAB*IDX_W-1:0] tbl_oldest,
  output logic                  all_done
);
  logic [NTAB-1:0] tbl_clear;

  for (genvar t = 0; t < NTAB; t++) begin : g_tbl
    assign tbl_clear[t] = !head_tbl[t] || tbl_empty[t] ||
                          (tbl_oldest[t*IDX_W +: IDX_W] != head_idx);
  end

  assign all_done = &tbl_clear;
endmodule

// File: rtl/retire_fsm.sv
module retire_fsm
  import retire_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    win_empty,
  input  logic    more_after_pop,
  input  logic    exec_done,
  input  logic    head_io,
  input  logic    head_wr,
  input  logic    io_done,
  input  logic    io_exc,
  input  logic    wr_done,
  input  logic    wr_exc,
  output rstate_e state
);
  rstate_e state_q, state_d;

  assign state = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (!win_empty) state_d = ST_WAIT_EXEC;
      ST_WAIT_EXEC:
        if (exec_done) begin
          if (head_io)      state_d = ST_DO_IO;
          else if (head_wr) state_d = ST_DO_WRITES;
          else              state_d = ST_RETIRE;
        end
      ST_DO_IO:
        if (io_done) begin
          if (io_exc)       state_d = ST_FLUSH;
          else if (head_wr) state_d = ST_DO_WRITES;
          else              state_d = ST_RETIRE;
        end
      ST_DO_WRITES:
        if (wr_done) state_d = wr_exc ? ST_FLUSH : ST_RETIRE;
      ST_RETIRE:
        state_d = more_after_pop ? ST_WAIT_EXEC : ST_IDLE;
      ST_FLUSH:
        state_d = ST_IDLE;
      default:
        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NTAB  = 3,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  output logic                  alloc_ready,
  input  logic                  alloc_io,
  input  logic                  alloc_wr,
  input  logic [NTAB-1:0]       alloc_tbl,
  output logic [IDX_W-1:0]      alloc_seq,
  input  logic [NTAB-1:0]       tbl_empty,
  input  logic [NTAB*IDX_W-1:0] tbl_oldest,
  output logic                  io_go,
  output logic [IDX_W-1:0]      io_seq,
  input  logic                  io_done,
  input  logic                  io_exc,
  output logic                  wr_go,
  output logic [IDX_W-1:0]      wr_seq,
  input  logic                  wr_done,
  input  logic                  wr_exc,
  output logic                  retire_valid,
  output logic [IDX_W-1:0]      retire_seq,
  output logic                  flush_valid,
  output logic [IDX_W-1:0]      flush_seq
);
  rstate_e          state;
  logic             push, pop, flush;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic             full, empty, more_after_pop;
  logic             head_io, head_wr;
  logic [NTAB-1:0]  head_tbl;
  logic             exec_done;

  assign flush       = (state == ST_FLUSH);
  assign pop         = (state == ST_RETIRE);
  assign alloc_ready = !full && !flush;
  assign push        = alloc_valid && alloc_ready;
  assign alloc_seq   = tail_idx;

  retire_window #(.DEPTH(DEPTH), .NTAB(NTAB), .IDX_W(IDX_W)) u_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .push           (push),
    .push_io        (alloc_io),
    .push_wr        (alloc_wr),
    .push_tbl       (alloc_tbl),
    .pop            (pop),
    .flush          (flush),
    .head_idx       (head_idx),
    .tail_idx       (tail_idx),
    .full           (full),
    .empty          (empty),
    .more_after_pop (more_after_pop),
    .head_io        (head_io),
    .head_wr        (head_wr),
    .head_tbl       (head_tbl)
  );

  retire_exec_chk #(.NTAB(NTAB), .IDX_W(IDX_W)) u_exec (
    .head_idx   (head_idx),
    .head_tbl   (head_tbl),
    .tbl_empty  (tbl_empty),
    .tbl_oldest (tbl_oldest),
    .all_done   (exec_done)
  );

  retire_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .win_empty      (empty),
    .more_after_pop (more_after_pop),
    .exec_done      (exec_done),
    .head_io        (head_io),
    .head_wr        (head_wr),
    .io_done        (io_done),
    .io_exc         (io_exc),
    .wr_done        (wr_done),
    .wr_exc         (wr_exc),
    .state          (state)
  );

  assign io_go        = (state == ST_DO_IO);
  assign wr_go        = (state == ST_DO_WRITES);
  assign retire_valid = pop;
  assign flush_valid  = flush;
  assign io_seq       = head_idx;
  assign wr_seq       = head_idx;
  assign retire_seq   = head_idx;
  assign flush_seq    = head_idx;
endmodule

// File: rtl/retire_ctrl_chk.sv
module retire_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             io_go,
  input logic [IDX_W-1:0] io_seq,
  input logic             io_done,
  input logic             io_exc,
  input logic             wr_go,
  input logic [IDX_W-1:0] wr_seq,
  input logic             wr_done,
  input logic             wr_exc,
  input logic             retire_valid,
  input logic             flush_valid
);
  AST_IO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    io_go && !io_done |=> io_go && io_seq == $past(io_seq)); // R3
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && !wr_done |=> wr_go && wr_seq == $past(wr_seq)); // R4
  AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_go && wr_go)); // R4
  AST_WR_THEN_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && wr_done && !wr_exc |=> retire_valid); // R5
  AST_IO_EXC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    io_go && io_done && io_exc |=> flush_valid && !retire_valid); // R6
  AST_WR_EXC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && wr_done && wr_exc |=> flush_valid && !retire_valid); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !io_go && !wr_go && !retire_valid && !alloc_ready); // R7
  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> !retire_valid); // R8
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !io_go && !wr_go |=> !flush_valid); // R9
endmodule

bind retire_ctrl retire_ctrl_chk #(.IDX_W(IDX_W)) u_retire_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_ready  (alloc_ready),
  .io_go        (io_go),
  .io_seq       (io_seq),
  .io_done      (io_done),
  .io_exc       (io_exc),
  .wr_go        (wr_go),
  .wr_seq       (wr_seq),
  .wr_done      (wr_done),
  .wr_exc       (wr_exc),
  .retire_valid (retire_valid),
  .flush_valid  (flush_valid)
);

// File: tb/test_retire_ctrl.sv
`timescale 1ns/1ps
module test_retire_ctrl;
  localparam int DEPTH = 8;
  localparam int NTAB  = 3;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_io = 1'b0, alloc_wr = 1'b0;
  logic [NTAB-1:0] alloc_tbl = '0;
  logic alloc_ready;
  logic [IDX_W-1:0] alloc_seq;
  logic [NTAB-1:0] tbl_empty;
  logic [NTAB*IDX_W-1:0] tbl_oldest;
  logic io_go, wr_go, retire_valid, flush_valid;
  logic [IDX_W-1:0] io_seq, wr_seq, retire_seq, flush_seq;
  logic io_done = 1'b0, io_exc = 1'b0, wr_done = 1'b0, wr_exc = 1'b0;

  int checks = 0;
  int errors = 0;

  logic            m_io  [DEPTH];
  logic            m_wr  [DEPTH];
  logic [NTAB-1:0] m_tbl [DEPTH];
  int m_head = 0, m_tail = 0, m_count = 0;
  bit m_execd = 1'b0;
  bit other_busy = 1'b0;
  logic [NTAB-1:0] younger = '0;

  always #5 clk = ~clk;

  retire_ctrl #(.DEPTH(DEPTH), .NTAB(NTAB)) i_retire_ctrl (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_io(alloc_io), .alloc_wr(alloc_wr), .alloc_tbl(alloc_tbl),
    .alloc_seq(alloc_seq),
    .tbl_empty(tbl_empty), .tbl_oldest(tbl_oldest),
    .io_go(io_go), .io_seq(io_seq), .io_done(io_done), .io_exc(io_exc),
    .wr_go(wr_go), .wr_seq(wr_seq), .wr_done(wr_done), .wr_exc(wr_exc),
    .retire_valid(retire_valid), .retire_seq(retire_seq),
    .flush_valid(flush_valid), .flush_seq(flush_seq)
  );

  // Node-table stub: the head's tables stay busy until the bench marks it executed.
  always_comb begin
    for (int t = 0; t < NTAB; t++) begin
      tbl_empty[t] = 1'b1;
      tbl_oldest[t*IDX_W +: IDX_W] = IDX_W'(m_head);
      if (m_count > 0 && !m_execd && m_tbl[m_head][t]) begin
        tbl_empty[t] = 1'b0;
      end else if (m_count > 0 && other_busy && !m_tbl[m_head][t]) begin
        tbl_empty[t] = 1'b0;
      end else if (younger[t]) begin
        tbl_empty[t] = 1'b0;
        tbl_oldest[t*IDX_W +: IDX_W] = IDX_W'((m_head + 1) % DEPTH);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_alloc(input bit io, input bit wr, input logic [NTAB-1:0] tbl);
    bit exp_rdy;
    exp_rdy = (m_count < DEPTH);
    chk(alloc_ready == exp_rdy, "R1 ready", int'(alloc_ready), int'(exp_rdy));
    chk(alloc_seq == IDX_W'(m_tail), "R1 seq", int'(alloc_seq), m_tail);
    alloc_valid = 1'b1; alloc_io = io; alloc_wr = wr; alloc_tbl = tbl;
    @(negedge clk);
    alloc_valid = 1'b0;
    if (exp_rdy) begin
      m_io[m_tail] = io; m_wr[m_tail] = wr; m_tbl[m_tail] = tbl;
      m_tail = (m_tail + 1) % DEPTH;
      m_count++;
    end
  endtask

  task automatic check_flush(input int hd);
    chk(flush_valid && flush_seq == IDX_W'(hd), "R6 flush", int'(flush_seq), hd);
    chk(!io_go && !wr_go && !retire_valid && !alloc_ready, "R7 quiet",
        int'({io_go, wr_go, retire_valid, alloc_ready}), 0);
    m_tail = m_head; m_count = 0; m_execd = 1'b0;
    @(negedge clk);
    chk(!flush_valid, "R6 pulse", int'(flush_valid), 0);
    chk(alloc_seq == IDX_W'(hd), "R6 next seq", int'(alloc_seq), hd);
    chk(alloc_ready, "R1 ready after flush", int'(alloc_ready), 1);
  endtask

  task automatic process_head(input bit exc_io, input bit exc_wr, input int dly);
    int hd;
    int n;
    hd = m_head;
    repeat (dly) begin
      @(negedge clk);
      chk(!io_go && !wr_go && !retire_valid, "R2 hold", int'({io_go, wr_go, retire_valid}), 0);
    end
    m_execd = 1'b1;
    if (m_io[hd]) begin
      n = 0;
      while (!io_go && n < 6) begin @(negedge clk); n++; end
      chk(io_go && io_seq == IDX_W'(hd), "R3 io release", int'(io_seq), hd);
      chk(!wr_go && !retire_valid, "R3 order", int'({wr_go, retire_valid}), 0);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(io_go && !wr_go, "R3 held", int'({io_go, wr_go}), 2);
      end
      io_done = 1'b1; io_exc = exc_io;
      @(negedge clk);
      io_done = 1'b0; io_exc = 1'b0;
      if (exc_io) begin check_flush(hd); return; end
    end
    if (m_wr[hd]) begin
      n = 0;
      while (!wr_go && n < 6) begin @(negedge clk); n++; end
      chk(wr_go && wr_seq == IDX_W'(hd), "R4 wr release", int'(wr_seq), hd);
      chk(!io_go && !retire_valid, "R4 order", int'({io_go, retire_valid}), 0);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(wr_go && !retire_valid, "R4 held", int'({wr_go, retire_valid}), 2);
      end
      wr_done = 1'b1; wr_exc = exc_wr;
      @(negedge clk);
      wr_done = 1'b0; wr_exc = 1'b0;
      if (exc_wr) begin check_flush(hd); return; end
      chk(retire_valid, "R5 retire after writes", int'(retire_valid), 1);
    end
    n = 0;
    while (!retire_valid && n < 6) begin @(negedge clk); n++; end
    chk(retire_valid && retire_seq == IDX_W'(hd), "R5 retire seq", int'(retire_seq), hd);
    m_head = (hd + 1) % DEPTH; m_count--; m_execd = 1'b0;
    @(negedge clk);
    chk(!retire_valid, "R8 no back-to-back", int'(retire_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!io_go && !wr_go && !retire_valid && !flush_valid, "R8 reset outputs",
        int'({io_go, wr_go, retire_valid, flush_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(alloc_ready && alloc_seq == '0, "R8 reset ready", int'(alloc_seq), 0);

    // Stray done/exception pulses while nothing is released (R9)
    do_alloc(1'b1, 1'b1, 3'b011);
    io_done = 1'b1; io_exc = 1'b1; wr_done = 1'b1; wr_exc = 1'b1;
    @(negedge clk);
    io_done = 1'b0; io_exc = 1'b0; wr_done = 1'b0; wr_exc = 1'b0;
    @(negedge clk);
    chk(!flush_valid && !io_go && !retire_valid, "R9 stray ignored",
        int'({flush_valid, io_go, retire_valid}), 0);
    process_head(1'b0, 1'b0, 3);

    // Unused table busy: must not block (R2)
    other_busy = 1'b1;
    do_alloc(1'b0, 1'b0, 3'b001);
    process_head(1'b0, 1'b0, 0);
    other_busy = 1'b0;

    // Younger nodes at table heads must not block (R2)
    younger = 3'b111;
    do_alloc(1'b1, 1'b0, 3'b110);
    process_head(1'b0, 1'b0, 2);
    younger = '0;

    // I/O exception with a younger entry behind it (R6)
    do_alloc(1'b1, 1'b1, 3'b010);
    do_alloc(1'b0, 1'b1, 3'b100);
    process_head(1'b1, 1'b0, 1);

    // Write exception without I/O (R6)
    do_alloc(1'b0, 1'b1, 3'b001);
    process_head(1'b0, 1'b1, 0);

    // Fill the window, refuse one more, then drain in order (R1, R8)
    for (int i = 0; i < DEPTH; i++) do_alloc(i[0], i[1], NTAB'(i % 7 + 1));
    chk(!alloc_ready, "R1 full", int'(alloc_ready), 0);
    do_alloc(1'b1, 1'b1, 3'b111);
    while (m_count > 0) process_head(1'b0, 1'b0, 1);

    // Random traffic
    for (int it = 0; it < 300; it++) begin
      younger = NTAB'($urandom);
      if (m_count < DEPTH && ($urandom % 2 == 0 || m_count == 0)) begin
        do_alloc(1'($urandom), 1'($urandom), NTAB'($urandom % 7 + 1));
      end else begin
        process_head(($urandom % 8) == 0, ($urandom % 8) == 0, int'($urandom % 4));
      end
    end
    younger = '0;
    while (m_count > 0) process_head(1'b0, 1'b0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule